// File: doc/BRIEF.md
# Power-Mode Control Register with Watchdog Interlock

This block holds an 8-bit power-mode control register and the small controller that acts on it. Software writes the register to pick what a later sleep request does. Bit 7 (standby select) chooses between light sleep and deep standby. Bit 6 (pin float) chooses whether the I/O pins float or keep their last value while in standby. The processor core signals a sleep request with a one-cycle pulse. The controller then moves from RUN to SLEEP or to STANDBY, and a wake interrupt brings it back to RUN.

A watchdog that is running must never be frozen by deep standby, so the block takes the watchdog's enable as an input. While that input is high, any write that tries to raise either control bit leaves the bit unchanged. Clearing a bit is always allowed. The mode state and two pad controls leave the block: a high-impedance enable and a hold enable. The pad ring and the clock controller use them.

Top module: `pwrmode_ctrl`

## Requirements
- R1: After reset the register reads 0x1F, mode_state is RUN (2'b00), and pin_float_en and pin_hold_en are both 0.
- R2: Bit 5 of the register always reads 0 and bits 4..0 always read 1, whatever value was written.
- R3: While wdt_run is 1, a write with bit 7 set does not change bit 7 from 0 to 1.
- R4: While wdt_run is 1, a write with bit 6 set does not change bit 6 from 0 to 1.
- R5: A write with wdt_run at 0 stores bits 7 and 6 as written, and a write that clears bit 7 or bit 6 takes effect whatever wdt_run is. The write is visible after the clock edge that takes it.
- R6: A sleep_req pulse in RUN while bit 7 is 0 gives mode_state SLEEP (2'b01) after the next clock edge.
- R7: A sleep_req pulse in RUN while bit 7 is 1 gives mode_state STANDBY (2'b10) after the next clock edge. The register value held before that edge decides the target, even when a write occurs in the same cycle.
- R8: wake_irq in SLEEP or STANDBY returns mode_state to RUN after the next clock edge. sleep_req outside RUN and wake_irq in RUN have no effect.
- R9: pin_float_en is 1 only in STANDBY with bit 6 at 1. pin_hold_en is 1 only in STANDBY with bit 6 at 0. Both are 0 in RUN and SLEEP.
- R10: Reset taken while in STANDBY at once returns mode_state to RUN and the register to 0x1F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write value |
| reg_rd_data | output | 8 | Current register value |
| wdt_run | input | 1 | Watchdog enabled; blocks raising bits 7 and 6 |
| sleep_req | input | 1 | One-cycle sleep request pulse from the core |
| wake_irq | input | 1 | Wake interrupt |
| mode_state | output | 2 | 00 RUN, 01 SLEEP, 10 STANDBY |
| pin_float_en | output | 1 | Pads to high impedance |
| pin_hold_en | output | 1 | Pads hold their last value |

## Verification
The assertions take sleep_req to be a single-cycle pulse and all inputs to be known once reset is released. One property checks the pulse rule rather than relying on it silently. The directed stimulus drives every input a fixed delay after the rising edge. It raises sleep_req for exactly one cycle, and it raises wake_irq only for single cycles that the scenario calls for. A request and a write that share a cycle are produced only on purpose, to probe the ordering rule of R7.

// File: rtl/pwrmode_pkg.sv
package pwrmode_pkg;

    localparam int REG_W     = 8;
    localparam int SEL_POS   = 7;
    localparam int FLT_POS   = 6;
    localparam int ZERO_POS  = 5;
    localparam int ONES_W    = 5;

    localparam logic [REG_W-1:0] ONES_MASK  = REG_W'((1 << ONES_W) - 1);
    localparam logic [REG_W-1:0] CTRL_MASK  = REG_W'((1 << SEL_POS) | (1 << FLT_POS));
    localparam logic [REG_W-1:0] RESET_IMG  = ONES_MASK;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_SLEEP = 2'b01,
        MODE_STBY  = 2'b10
    } mode_e;

    typedef struct packed {
        logic [REG_W-1:0] img;
    } ctl_reg_t;

    typedef struct packed {
        mode_e mode;
    } fsm_t;

endpackage

// File: rtl/pwrmode_reg.sv
module pwrmode_reg
    import pwrmode_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         wdt_run,
    output logic [W-1:0] rd_data,
    output logic         sel_stby,
    output logic         flt_pins
);

    localparam int N_GUARD = 2;
    localparam int GUARD_POS [N_GUARD] = '{SEL_POS, FLT_POS};

    ctl_reg_t reg_d, reg_q;
    logic [W-1:0] cand;

    always_comb begin
        reg_d = reg_q;
        cand  = wr_data;
        // Guarded bits may only be lowered while the watchdog runs.
        for (int i = 0; i < N_GUARD; i++) begin
            if (wdt_run) begin
                cand[GUARD_POS[i]] = reg_q.img[GUARD_POS[i]] & wr_data[GUARD_POS[i]];
            end
        end
        if (wr_en) begin
            reg_d.img = (cand & CTRL_MASK) | ONES_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q.img <= RESET_IMG;
        end else begin
            reg_q <= reg_d;
        end
    end

    assign rd_data  = reg_q.img;
    assign sel_stby = reg_q.img[SEL_POS];
    assign flt_pins = reg_q.img[FLT_POS];

endmodule

// File: rtl/pwrmode_fsm.sv
module pwrmode_fsm
    import pwrmode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sleep_req,
    input  logic  wake_irq,
    input  logic  sel_stby,
    output mode_e mode
);

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.mode)
            MODE_RUN: begin
                if (sleep_req) begin
                    fsm_d.mode = sel_stby ? MODE_STBY : MODE_SLEEP;
                end
            end
            MODE_SLEEP, MODE_STBY: begin
                if (wake_irq) begin
                    fsm_d.mode = MODE_RUN;
                end
            end
            default: fsm_d.mode = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.mode <= MODE_RUN;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign mode = fsm_q.mode;

endmodule

// File: rtl/pwrmode_pins.sv
module pwrmode_pins
    import pwrmode_pkg::*;
(
    input  mode_e mode,
    input  logic  flt_pins,
    output logic  float_en,
    output logic  hold_en
);

    logic in_stby;

    always_comb begin
        in_stby  = (mode == MODE_STBY);
        float_en = in_stby &  flt_pins;
        hold_en  = in_stby & ~flt_pins;
    end

endmodule

// File: rtl/pwrmode_ctrl.sv
module pwrmode_ctrl
    import pwrmode_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wr_data,
    output logic [REG_W-1:0] reg_rd_data,
    input  logic             wdt_run,
    input  logic             sleep_req,
    input  logic             wake_irq,
    output logic [1:0]       mode_state,
    output logic             pin_float_en,
    output logic             pin_hold_en
);

    logic  sel_stby;
    logic  flt_pins;
    mode_e mode;

    pwrmode_reg #(.W(REG_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .wdt_run  (wdt_run),
        .rd_data  (reg_rd_data),
        .sel_stby (sel_stby),
        .flt_pins (flt_pins)
    );

    pwrmode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .wake_irq  (wake_irq),
        .sel_stby  (sel_stby),
        .mode      (mode)
    );

    pwrmode_pins u_pins (
        .mode     (mode),
        .flt_pins (flt_pins),
        .float_en (pin_float_en),
        .hold_en  (pin_hold_en)
    );

    assign mode_state = mode;

endmodule

// File: rtl/pwrmode_chk.sv
module pwrmode_chk
    import pwrmode_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic [REG_W-1:0] reg_wr_data,
    input logic [REG_W-1:0] reg_rd_data,
    input logic             wdt_run,
    input logic             sleep_req,
    input logic             wake_irq,
    input logic [1:0]       mode_state,
    input logic             pin_float_en,
    input logic             pin_hold_en
);

    // Input rule: sleep requests are single-cycle pulses.
    p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> !sleep_req);

    p_keep_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (reg_rd_data[ZERO_POS] == 1'b0) && (reg_rd_data[ONES_W-1:0] == ONES_MASK[ONES_W-1:0]));

    p_no_raise_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && wdt_run && !reg_rd_data[SEL_POS]) |=> !reg_rd_data[SEL_POS]);

    p_no_raise_flt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && wdt_run && !reg_rd_data[FLT_POS]) |=> !reg_rd_data[FLT_POS]);

    p_clear_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !reg_wr_data[SEL_POS] && !reg_wr_data[FLT_POS]) |=>
            (!reg_rd_data[SEL_POS] && !reg_rd_data[FLT_POS]));

    p_enter_sleep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state == MODE_RUN && sleep_req && !reg_rd_data[SEL_POS]) |=> mode_state == MODE_SLEEP);

    p_enter_stby_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state == MODE_RUN && sleep_req && reg_rd_data[SEL_POS]) |=> mode_state == MODE_STBY);

    p_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state != MODE_RUN && wake_irq) |=> mode_state == MODE_RUN);

    p_stay_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state != MODE_RUN && !wake_irq) |=> $stable(mode_state));

    p_pins_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state != MODE_STBY) |-> (!pin_float_en && !pin_hold_en));

    p_pins_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state == MODE_STBY) |-> $onehot({pin_float_en, pin_hold_en}));

endmodule

bind pwrmode_ctrl pwrmode_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_en    (reg_wr_en),
    .reg_wr_data  (reg_wr_data),
    .reg_rd_data  (reg_rd_data),
    .wdt_run      (wdt_run),
    .sleep_req    (sleep_req),
    .wake_irq     (wake_irq),
    .mode_state   (mode_state),
    .pin_float_en (pin_float_en),
    .pin_hold_en  (pin_hold_en)
);

// File: tb/tb_pwrmode_ctrl.sv
module tb_pwrmode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = 8'h00;
    logic [7:0] reg_rd_data;
    logic       wdt_run = 1'b0;
    logic       sleep_req = 1'b0;
    logic       wake_irq = 1'b0;
    logic [1:0] mode_state;
    logic       pin_float_en;
    logic       pin_hold_en;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pwrmode_ctrl dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr_en    (reg_wr_en),
        .reg_wr_data  (reg_wr_data),
        .reg_rd_data  (reg_rd_data),
        .wdt_run      (wdt_run),
        .sleep_req    (sleep_req),
        .wake_irq     (wake_irq),
        .mode_state   (mode_state),
        .pin_float_en (pin_float_en),
        .pin_hold_en  (pin_hold_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic write_reg(input logic [7:0] v);
        reg_wr_en = 1'b1;
        reg_wr_data = v;
        tick();
        reg_wr_en = 1'b0;
        reg_wr_data = 8'h00;
    endtask

    task automatic pulse_sleep();
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
    endtask

    task automatic pulse_wake();
        wake_irq = 1'b1;
        tick();
        wake_irq = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reg", reg_rd_data, 8'h1F);
        check("R1 mode", {6'd0, mode_state}, 8'h00);
        check("R1 pins", {6'd0, pin_float_en, pin_hold_en}, 8'h00);
    endtask

    task automatic t_fixed_bits();
        wdt_run = 1'b0;
        write_reg(8'h20);
        check("R2 write 0x20", reg_rd_data, 8'h1F);
        write_reg(8'h3F);
        check("R2 write 0x3F", reg_rd_data, 8'h1F);
        write_reg(8'hC0);
        check("R2 R5 write 0xC0", reg_rd_data, 8'hDF);
        write_reg(8'h00);
        check("R5 clear", reg_rd_data, 8'h1F);
    endtask

    task automatic t_wdt_block();
        wdt_run = 1'b1;
        write_reg(8'h80);
        check("R3 sel blocked", reg_rd_data, 8'h1F);
        write_reg(8'h40);
        check("R4 flt blocked", reg_rd_data, 8'h1F);
        write_reg(8'hFF);
        check("R3 R4 both blocked", reg_rd_data, 8'h1F);
        wdt_run = 1'b0;
        write_reg(8'hC0);
        wdt_run = 1'b1;
        write_reg(8'hC0);
        check("R3 R4 kept set", reg_rd_data, 8'hDF);
        write_reg(8'h40);
        check("R5 clear sel under wdt", reg_rd_data, 8'h5F);
        write_reg(8'h00);
        check("R5 clear flt under wdt", reg_rd_data, 8'h1F);
        wdt_run = 1'b0;
    endtask

    task automatic t_sleep();
        write_reg(8'h40);
        pulse_sleep();
        check("R6 sleep", {6'd0, mode_state}, 8'h01);
        check("R9 pins in sleep", {6'd0, pin_float_en, pin_hold_en}, 8'h00);
        write_reg(8'h80);
        pulse_sleep();
        check("R8 req ignored in sleep", {6'd0, mode_state}, 8'h01);
        pulse_wake();
        check("R8 wake from sleep", {6'd0, mode_state}, 8'h00);
        pulse_wake();
        check("R8 wake ignored in run", {6'd0, mode_state}, 8'h00);
        write_reg(8'h00);
    endtask

    task automatic t_stby_hold();
        write_reg(8'h80);
        pulse_sleep();
        check("R7 standby", {6'd0, mode_state}, 8'h02);
        check("R9 hold", {6'd0, pin_float_en, pin_hold_en}, 8'h01);
        pulse_wake();
        check("R8 wake from standby", {6'd0, mode_state}, 8'h00);
        check("R9 pins after wake", {6'd0, pin_float_en, pin_hold_en}, 8'h00);
    endtask

    task automatic t_stby_float();
        write_reg(8'hC0);
        pulse_sleep();
        check("R7 standby float", {6'd0, mode_state}, 8'h02);
        check("R9 float", {6'd0, pin_float_en, pin_hold_en}, 8'h02);
        pulse_wake();
        write_reg(8'h00);
    endtask

    task automatic t_same_cycle();
        reg_wr_en = 1'b1;
        reg_wr_data = 8'h80;
        sleep_req = 1'b1;
        tick();
        reg_wr_en = 1'b0;
        sleep_req = 1'b0;
        check("R7 old value picks sleep", {6'd0, mode_state}, 8'h01);
        check("R5 write in same cycle", reg_rd_data, 8'h9F);
        pulse_wake();
        write_reg(8'h00);
    endtask

    task automatic t_reset_stby();
        write_reg(8'hC0);
        pulse_sleep();
        check("R10 pre standby", {6'd0, mode_state}, 8'h02);
        rst_n = 1'b0;
        #1;
        check("R10 mode", {6'd0, mode_state}, 8'h00);
        check("R10 reg", reg_rd_data, 8'h1F);
        check("R10 pins", {6'd0, pin_float_en, pin_hold_en}, 8'h00);
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick();
        tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_fixed_bits();
        t_wdt_block();
        t_sleep();
        t_stby_hold();
        t_stby_float();
        t_same_cycle();
        t_reset_stby();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule